// File: doc/BRIEF.md
# LDO Start-Up Current-Limit Sequencer

This block is the digital controller that brings a linear regulator up from off to regulation. It takes four comparator flags from the analog side: the enable-pin level, input supply above its under-voltage lockout point, regulator output above a low threshold (about 0.75 V), and regulator output above 90% of its target. From these it drives an LDO enable, a two-bit current-limit level select and an inhibit that keeps the switching regulator from starting.

The flags are asynchronous to the controller clock. Each one passes through a synchronizer and then a stability filter before the state machine sees it. Start-up opens at the lowest current limit, which is the short-circuit protection level. The limit rises one level for each output threshold crossed. The switching regulator is released only once the output has passed the 90% point. The current limit never steps down during a start-up. Losing the enable or the input supply shuts the regulator off at once and inhibits the switcher again. The next start-up then begins from the lowest level.

Top module: `ldo_startup_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `ldo_en_o` = 0, `ilim_sel_o` = 2'b00 and `pwm_inhibit_o` = 1.
- R2: Start-up begins only when both the filtered enable flag and the filtered input-supply flag are high. With only one of them high, the outputs stay in the off state.
- R3: The current-limit select is encoded as 2'b00 off, 2'b01 ~65 mA, 2'b10 ~115 mA and 2'b11 ~200 mA. A start-up first selects 2'b01 and raises `ldo_en_o`.
- R4: Once the filtered low-threshold flag is high during a start-up, the select moves to 2'b10.
- R5: Once the filtered 90% flag is high, the select moves to 2'b11 and `pwm_inhibit_o` falls to 0.
- R6: `pwm_inhibit_o` is 1 in every state except the one where the select is 2'b11.
- R7: If the filtered enable flag or the filtered input-supply flag is low, the next clock edge gives `ldo_en_o` = 0, select 2'b00 and `pwm_inhibit_o` = 1. This holds from any state.
- R8: During a start-up the select never decreases. An output dip below either threshold after 2'b11 is reached leaves the outputs unchanged.
- R9: Each flag passes through a 2-flop synchronizer and a 4-cycle stability filter. A change held for 3 cycles or less is ignored. A held change reaches the outputs exactly 7 clock edges after it is applied.
- R10: The select rises by at most one level per clock. If both output flags are already high at enable, the outputs show 2'b01, then 2'b10, then 2'b11 on consecutive cycles.
- R11: After a shutdown, a new start-up begins again at 2'b01, even if the output flags are still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_pin_i | input | 1 | Enable-pin comparator flag (asynchronous) |
| vin_ok_i | input | 1 | Input supply above lockout flag (asynchronous) |
| vout_lo_i | input | 1 | Output above low threshold flag (asynchronous) |
| vout_90_i | input | 1 | Output above 90% of target flag (asynchronous) |
| ldo_en_o | output | 1 | LDO enable |
| ilim_sel_o | output | 2 | Current-limit level select |
| pwm_inhibit_o | output | 1 | Holds the switching regulator off when 1 |

## Verification
The sequencer is driven through three kinds of ramp:
- **Ordinary ramp:** the two output flags rise one after the other. This shows each level is reached by its own threshold.
- **Pre-charged output:** both output flags are already high at enable. This separates a one-level-per-cycle climb from a direct jump to the top limit.
- **Restart:** a ramp is interrupted and then resumed with the output flags still high. This shows the controller starts again at the lowest level.

Pulses of three cycles on an output flag and on the enable flag check that the filter rejects them. Dips of the output flags after regulation show the limit does not step down. Edge-exact sampling at 6 and 7 edges after a change pins the latency.

// File: rtl/ldo_seq_pkg.sv
// Package: shared encodings for the LDO start-up sequencer.
// Assumes: 2-bit current-limit select is decoded by the analog limit circuit.
package ldo_seq_pkg;

    // Current-limit select codes, decoded by the analog limit circuit
    typedef enum logic [1:0] {
        ILIM_OFF  = 2'b00,
        ILIM_LOW  = 2'b01,
        ILIM_MID  = 2'b10,
        ILIM_HIGH = 2'b11
    } ilim_e;

    // Sequencer phases
    typedef enum logic [1:0] {
        PH_OFF,
        PH_SOFT,
        PH_RAMP,
        PH_REG
    } phase_e;

    // Flag indices inside the filtered flag vector
    localparam int FLAG_EN   = 0;
    localparam int FLAG_VIN  = 1;
    localparam int FLAG_LO   = 2;
    localparam int FLAG_HI   = 3;
    localparam int NUM_FLAGS = 4;

endpackage

// File: rtl/ldo_flag_filter.sv
// Module: ldo_flag_filter
// Synchronizes one asynchronous comparator flag and passes a new level on
// only after it has been seen unchanged for STABLE_CYCLES consecutive clocks.
// Assumes: SYNC_STAGES >= 2, STABLE_CYCLES >= 1, synchronous active-low reset.
module ldo_flag_filter #(
    parameter int SYNC_STAGES   = 2,
    parameter int STABLE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CW = $clog2(STABLE_CYCLES + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          cnt_q;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    // Synchronizer chain: shift the raw flag in.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
    end

    // Stability filter: count cycles of disagreement, adopt after enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            filt_o <= 1'b0;
        end else if (synced == filt_o) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(STABLE_CYCLES - 1)) begin
            cnt_q  <= '0;
            filt_o <= synced;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ldo_seq_fsm.sv
// Module: ldo_seq_fsm
// Phase machine for the LDO start-up. It climbs one phase at a time as the
// output thresholds are crossed, never steps down, and returns to off as
// soon as the start condition is lost.
// Assumes: inputs are already synchronized and filtered.
module ldo_seq_fsm
    import ldo_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   go_i,
    input  logic   vout_lo_i,
    input  logic   vout_hi_i,
    output phase_e phase_o
);
    phase_e phase_q, phase_d;

    // Next-phase logic: upward only, off whenever the start condition drops.
    always_comb begin
        phase_d = phase_q;
        if (!go_i) begin
            phase_d = PH_OFF;
        end else begin
            unique case (phase_q)
                PH_OFF:  phase_d = PH_SOFT;
                PH_SOFT: if (vout_lo_i || vout_hi_i) phase_d = PH_RAMP;
                PH_RAMP: if (vout_hi_i) phase_d = PH_REG;
                PH_REG:  phase_d = PH_REG;
                default: phase_d = PH_OFF;
            endcase
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_OFF;
        else        phase_q <= phase_d;
    end

    assign phase_o = phase_q;
endmodule

// File: rtl/ldo_seq_outdec.sv
// Module: ldo_seq_outdec
// Decodes the sequencer phase into the LDO enable, the current-limit select
// and the switcher inhibit.
// Assumes: phase input comes straight from a register (outputs glitch-free
// enough for slow analog controls).
module ldo_seq_outdec
    import ldo_seq_pkg::*;
(
    input  phase_e     phase_i,
    output logic       ldo_en_o,
    output logic [1:0] ilim_sel_o,
    output logic       pwm_inhibit_o
);
    // Phase to output decode.
    always_comb begin
        ldo_en_o      = 1'b1;
        pwm_inhibit_o = 1'b1;
        ilim_sel_o    = ILIM_OFF;
        unique case (phase_i)
            PH_OFF:  ldo_en_o = 1'b0;
            PH_SOFT: ilim_sel_o = ILIM_LOW;
            PH_RAMP: ilim_sel_o = ILIM_MID;
            PH_REG: begin
                ilim_sel_o    = ILIM_HIGH;
                pwm_inhibit_o = 1'b0;
            end
            default: ldo_en_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/ldo_startup_seq.sv
// Module: ldo_startup_seq (top)
// LDO start-up current-limit sequencer: filters the four comparator flags,
// runs the phase machine and decodes the analog control outputs.
// Assumes: all four flag inputs are asynchronous; synchronous active-low reset.
module ldo_startup_seq
    import ldo_seq_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int STABLE_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_pin_i,
    input  logic       vin_ok_i,
    input  logic       vout_lo_i,
    input  logic       vout_90_i,
    output logic       ldo_en_o,
    output logic [1:0] ilim_sel_o,
    output logic       pwm_inhibit_o
);
    logic [NUM_FLAGS-1:0] raw_flags;
    logic [NUM_FLAGS-1:0] filt_flags;
    logic                 go_filt;
    phase_e               phase;

    assign raw_flags[FLAG_EN]  = en_pin_i;
    assign raw_flags[FLAG_VIN] = vin_ok_i;
    assign raw_flags[FLAG_LO]  = vout_lo_i;
    assign raw_flags[FLAG_HI]  = vout_90_i;

    // One synchronizer and filter per comparator flag.
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        ldo_flag_filter #(
            .SYNC_STAGES  (SYNC_STAGES),
            .STABLE_CYCLES(STABLE_CYCLES)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_i (raw_flags[i]),
            .filt_o(filt_flags[i])
        );
    end

    assign go_filt = filt_flags[FLAG_EN] & filt_flags[FLAG_VIN];

    ldo_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_i     (go_filt),
        .vout_lo_i(filt_flags[FLAG_LO]),
        .vout_hi_i(filt_flags[FLAG_HI]),
        .phase_o  (phase)
    );

    ldo_seq_outdec u_dec (
        .phase_i      (phase),
        .ldo_en_o     (ldo_en_o),
        .ilim_sel_o   (ilim_sel_o),
        .pwm_inhibit_o(pwm_inhibit_o)
    );
endmodule

// File: rtl/ldo_seq_checker.sv
// Module: ldo_seq_checker
// Protocol checks on the sequencer outputs against the filtered start
// condition. Bound to the top module below.
module ldo_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       go_f,
    input logic       ldo_en,
    input logic [1:0] ilim,
    input logic       pwm_inh
);
    AST_SHUTDOWN_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        !go_f |=> (ilim == 2'b00 && !ldo_en && pwm_inh)); // R7

    AST_NO_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        go_f |=> (ilim >= $past(ilim))); // R8

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        go_f |=> ({1'b0, ilim} <= {1'b0, $past(ilim)} + 3'd1)); // R10

    AST_INHIBIT_UNTIL_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_inh |-> (ilim == 2'b11 && ldo_en)); // R6

    AST_ENABLE_WITH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ldo_en == (ilim != 2'b00)); // R3

    AST_START_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ldo_en) |-> (ilim == 2'b01)); // R11
endmodule

bind ldo_startup_seq ldo_seq_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_f   (go_filt),
    .ldo_en (ldo_en_o),
    .ilim   (ilim_sel_o),
    .pwm_inh(pwm_inhibit_o)
);

// File: tb/tb_ldo_startup_seq.sv
// Scoreboard bench: the driver pushes expected output items, the monitor pops
// and compares them at the falling edge after they are queued.
module tb_ldo_startup_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_pin = 1'b0, vin_ok = 1'b0, vlo = 1'b0, vhi = 1'b0;
    logic       ldo_en;
    logic [1:0] ilim;
    logic       inh;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic       en;
        logic [1:0] lim;
        logic       inh;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    ldo_startup_seq dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_pin_i     (en_pin),
        .vin_ok_i     (vin_ok),
        .vout_lo_i    (vlo),
        .vout_90_i    (vhi),
        .ldo_en_o     (ldo_en),
        .ilim_sel_o   (ilim),
        .pwm_inhibit_o(inh)
    );

    // Driver helper: queue one expected output item.
    task automatic expect_out(input logic e, input logic [1:0] l, input logic h, input string tag);
        exp_t it;
        it.en = e; it.lim = l; it.inh = h; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Driver helper: wait n rising edges, then stop at the falling edge.
    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Monitor: pop and compare each queued item.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                exp_t it;
                it = sb_q.pop_front();
                n_tests++;
                if (ldo_en !== it.en || ilim !== it.lim || inh !== it.inh) begin
                    n_fail++;
                    $display("FAIL %s: got en=%b lim=%b inh=%b, expected en=%b lim=%b inh=%b",
                             it.tag, ldo_en, ilim, inh, it.en, it.lim, it.inh);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: got running, expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        @(negedge clk);
        edges(3);
        expect_out(0, 2'b00, 1, "R1 during reset");
        rst_n = 1'b1;
        edges(1);
        expect_out(0, 2'b00, 1, "R1 after reset");

        en_pin = 1'b1;
        edges(10);
        expect_out(0, 2'b00, 1, "R2 enable only");
        en_pin = 1'b0; vin_ok = 1'b1;
        edges(10);
        expect_out(0, 2'b00, 1, "R2 supply only");

        en_pin = 1'b1;
        edges(6);
        expect_out(0, 2'b00, 1, "R9 not yet at edge 6");
        edges(1);
        expect_out(1, 2'b01, 1, "R3 low limit at edge 7");

        vlo = 1'b1;
        edges(10);
        expect_out(1, 2'b10, 1, "R4 mid limit, R6 inhibit held");

        vhi = 1'b1;
        edges(3);
        vhi = 1'b0;
        edges(10);
        expect_out(1, 2'b10, 1, "R9 3-cycle pulse ignored");

        vhi = 1'b1;
        edges(10);
        expect_out(1, 2'b11, 0, "R5 top limit, switcher released");

        vlo = 1'b0; vhi = 1'b0;
        edges(10);
        expect_out(1, 2'b11, 0, "R8 dip does not lower limit");

        vin_ok = 1'b0;
        edges(6);
        expect_out(1, 2'b11, 0, "R9 shutdown not yet at edge 6");
        edges(1);
        expect_out(0, 2'b00, 1, "R7 off after supply loss");

        vlo = 1'b1; vhi = 1'b1;
        edges(10);
        vin_ok = 1'b1;
        edges(7);
        expect_out(1, 2'b01, 1, "R11 restart at low, R10 step 1");
        edges(1);
        expect_out(1, 2'b10, 1, "R10 step 2");
        edges(1);
        expect_out(1, 2'b11, 0, "R10 step 3");

        en_pin = 1'b0;
        edges(3);
        en_pin = 1'b1;
        edges(10);
        expect_out(1, 2'b11, 0, "R9 enable pulse ignored");

        en_pin = 1'b0;
        edges(7);
        expect_out(0, 2'b00, 1, "R7 off after enable loss");

        vlo = 1'b0; vhi = 1'b0;
        en_pin = 1'b1;
        edges(10);
        expect_out(1, 2'b01, 1, "R11 restart holds at low");

        edges(2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule